// File: doc/BRIEF.md
# Vectored Three-Source Interrupt Controller

This block collects interrupt requests for a small 8-bit processor core from three sources: an active-low external pin, a one-cycle timer overflow pulse and a one-cycle end-of-conversion pulse from an analog-to-digital converter. Each source latches into its own request flag. The CPU reads and writes those flags, three per-source enables and a global enable through one 8-bit control register.

An internal phase counter divides the clock into machine cycles of `CYC_LEN` clocks. At the last clock of each machine cycle the controller looks at the flags it holds. If a request is allowed, it chooses the highest-priority one and sends the core a one-cycle call request together with a fixed vector address. It then clears the flag it serviced and the global enable. The core reports a full return stack, which holds off acceptance. The core also reports its two return kinds, and only the return-from-interrupt kind turns the global enable back on.

Top module: `irq_ctl3`

## Requirements
- R1: Register image on `reg_rdata`: bit 0 global enable, bit 1 pin enable, bit 2 timer enable, bit 3 converter enable, bit 4 pin flag, bit 5 timer flag, bit 6 converter flag. Bit 7 always reads 0. A write with `reg_we` loads bits 6..0 from `reg_wdata`.
- R2: The pin is synchronised through two flops. A high-to-low transition on `int_pin_n` sets the pin flag. A steady low level and a rising transition set nothing.
- R3: A high `tmr_ovf` sets the timer flag, and a high `adc_eoc` sets the converter flag.
- R4: A hardware set event wins over a software write of 0 to the same flag in the same clock.
- R5: A source is accepted only at the sampling clock, which is the last clock of each `CYC_LEN`-clock machine cycle counted from reset release. Acceptance also needs the source's flag and enable both at 1, the global enable at 1, and `stack_full` at 0 in that clock. A request that arrives inside a machine cycle is serviced at the end of that machine cycle.
- R6: Among accepted candidates the pin source wins over the timer, and the timer wins over the converter. The vectors are 0x004 for the pin, 0x008 for the timer and 0x00C for the converter.
- R7: Acceptance clears the serviced flag and the global enable. The flags of lower-priority sources that are still pending stay set.
- R8: `call_req` is a one-clock pulse in the clock right after the sampling clock, and `call_vec` is valid in that same clock.
- R9: `reti_strobe` sets the global enable. `ret_strobe` leaves it unchanged.
- R10: After reset the register reads 0x00 and `call_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_pin_n | input | 1 | External request pin, falling-edge active |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_eoc | input | 1 | Conversion-done pulse |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read image |
| stack_full | input | 1 | Return stack cannot take another entry |
| ret_strobe | input | 1 | Core executed a plain return |
| reti_strobe | input | 1 | Core executed a return-from-interrupt |
| call_req | output | 1 | Interrupt call request pulse |
| call_vec | output | VEC_W | Vector address for the call |

## Verification
The bench builds the block with `CYC_LEN` = 4 and `VEC_W` = 12. A machine cycle of four clocks lets the bench start every write on phase 0 and read the outcome one machine cycle later. The bench sweeps all 128 register values against both `stack_full` levels and derives the expected vector and register image arithmetically. The short machine cycle also makes it cheap to probe a request that arrives in mid-cycle, and to hold the pin low across several machine cycles to show that a steady level does not set the flag again.

// File: rtl/irq_ctl3.sv
module irq_ctl3 #(
  parameter int VEC_W   = 12,
  parameter int CYC_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_pin_n,
  input  logic             tmr_ovf,
  input  logic             adc_eoc,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             stack_full,
  input  logic             ret_strobe,
  input  logic             reti_strobe,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vec
);
  localparam int PH_W = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

  logic [PH_W-1:0] phase;
  logic [2:0]      pin_sync;
  logic [2:0]      flag, en;
  logic            gie;

  logic       tick, take, pin_fall;
  logic [2:0] hw_set, act, grant, flag_base;

  assign tick     = (phase == PH_LAST);
  assign pin_fall = pin_sync[2] & ~pin_sync[1];
  assign hw_set   = {adc_eoc, tmr_ovf, pin_fall};
  assign act      = flag & en;
  assign take     = tick & gie & ~stack_full & (|act);
  assign grant    = act[0] ? 3'b001 : act[1] ? 3'b010 : act[2] ? 3'b100 : 3'b000;
  assign flag_base = reg_we ? reg_wdata[6:4] : flag;

  assign reg_rdata = {1'b0, flag, en, gie};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= '0;
      pin_sync <= 3'b111;
      flag     <= '0;
      en       <= '0;
      gie      <= 1'b0;
      call_req <= 1'b0;
      call_vec <= '0;
    end else begin
      phase    <= tick ? '0 : phase + 1'b1;
      pin_sync <= {pin_sync[1:0], int_pin_n};
      flag     <= (flag_base & ~(take ? grant : 3'b000)) | hw_set;
      if (reg_we) en <= reg_wdata[3:1];
      if (take)             gie <= 1'b0;
      else if (reti_strobe) gie <= 1'b1;
      else if (reg_we)      gie <= reg_wdata[0];
      call_req <= take;
      if (take)
        call_vec <= grant[0] ? VEC_W'(12'h004) : grant[1] ? VEC_W'(12'h008) : VEC_W'(12'h00C);
    end
  end
endmodule

module irq_ctl3_chk #(parameter int VEC_W = 12) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       reg_rdata,
  input logic             reg_we,
  input logic             stack_full,
  input logic             ret_strobe,
  input logic             reti_strobe,
  input logic             call_req,
  input logic [VEC_W-1:0] call_vec
);
  p_bit7_zero_r1: assert property (@(posedge clk) disable iff (!rst_n) !reg_rdata[7]);
  p_stack_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !$past(stack_full));
  p_vec_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vec == VEC_W'(4) || call_vec == VEC_W'(8) || call_vec == VEC_W'(12)));
  p_gie_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !reg_rdata[0]);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) call_req |=> !call_req);
  p_reti_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_strobe && !reg_rdata[0]) |=> reg_rdata[0]);
  p_ret_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_strobe && !reti_strobe && !reg_we && !reg_rdata[0]) |=> !reg_rdata[0]);
endmodule

bind irq_ctl3 irq_ctl3_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .reg_we(reg_we),
  .stack_full(stack_full), .ret_strobe(ret_strobe), .reti_strobe(reti_strobe),
  .call_req(call_req), .call_vec(call_vec)
);

// File: tb/test_irq_ctl3.sv
module test_irq_ctl3;
  localparam int VEC_W = 12;
  localparam int CYC_LEN = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic int_pin_n = 1'b1, tmr_ovf = 1'b0, adc_eoc = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic stack_full = 1'b0, ret_strobe = 1'b0, reti_strobe = 1'b0, call_req;
  logic [VEC_W-1:0] call_vec;
  int checks = 0, errors = 0, bph = 0, cyc = 0;

  always #2.5 clk = ~clk;

  irq_ctl3 #(.VEC_W(VEC_W), .CYC_LEN(CYC_LEN)) i_irq_ctl3 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) bph <= 0;
    else bph <= (bph == CYC_LEN - 1) ? 0 : bph + 1;
  end

  initial begin
    wait (cyc == 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic to_ph0();
    do @(negedge clk); while (bph != 0);
  endtask

  task automatic wr(logic [7:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset image", reg_rdata, 8'h00);
    chk("R10 reset call", call_req, 1'b0);

    for (int sf = 0; sf < 2; sf++) begin
      for (int v = 0; v < 256; v += 2) begin
        logic [2:0] f, e, a, g;
        logic acc;
        int calls, gidx;
        logic [7:0] img;
        for (int h = 0; h < 2; h++) begin
          logic [7:0] w;
          w = 8'(v + h);
          to_ph0();
          stack_full = sf[0];
          f = w[6:4]; e = w[3:1]; a = f & e;
          acc = w[0] && !sf[0] && (a != 0);
          gidx = a[0] ? 0 : a[1] ? 1 : 2;
          g = acc ? 3'(1 << gidx) : 3'b000;
          img = {1'b0, f & ~g, e, acc ? 1'b0 : w[0]};
          reg_we = 1'b1; reg_wdata = w;
          calls = 0;
          for (int k = 0; k < CYC_LEN; k++) begin
            @(negedge clk);
            reg_we = 1'b0;
            if (k < CYC_LEN - 1) calls += call_req;
          end
          chk("R5 no early call", calls, 0);
          chk("R5 R8 call at sample", call_req, acc);
          if (acc) chk("R6 vector", call_vec, 32'(4 * (gidx + 1)));
          chk("R1 R7 image after", reg_rdata, img);
        end
      end
    end
    stack_full = 1'b0;

    to_ph0();
    wr(8'h05);
    tmr_ovf = 1'b1;
    @(negedge clk);
    tmr_ovf = 1'b0;
    chk("R3 timer flag set mid cycle", reg_rdata, 8'h25);
    chk("R5 wait for sample", call_req, 1'b0);
    @(negedge clk);
    chk("R5 still waiting", call_req, 1'b0);
    @(negedge clk);
    chk("R8 call after sample", call_req, 1'b1);
    chk("R6 timer vector", call_vec, 12'h008);
    chk("R7 cleared", reg_rdata, 8'h04);
    @(negedge clk);
    chk("R8 one clock pulse", call_req, 1'b0);

    wr(8'h00);
    int_pin_n = 1'b0;
    wait_n(5);
    chk("R2 falling edge sets", reg_rdata, 8'h10);
    wr(8'h00);
    wait_n(10);
    chk("R2 low level no set", reg_rdata, 8'h00);
    int_pin_n = 1'b1;
    wait_n(6);
    chk("R2 rising edge no set", reg_rdata, 8'h00);
    int_pin_n = 1'b0;
    wait_n(6);
    chk("R2 second fall sets", reg_rdata, 8'h10);
    int_pin_n = 1'b1;
    wait_n(4);
    wr(8'h00);

    adc_eoc = 1'b1;
    @(negedge clk);
    adc_eoc = 1'b0;
    chk("R3 converter flag", reg_rdata, 8'h40);
    wr(8'h00);

    wr(8'h20);
    reg_we = 1'b1; reg_wdata = 8'h00; tmr_ovf = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tmr_ovf = 1'b0;
    chk("R4 set beats clear", reg_rdata, 8'h20);
    wr(8'h00);

    ret_strobe = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0;
    chk("R9 ret keeps off", reg_rdata[0], 1'b0);
    reti_strobe = 1'b1;
    @(negedge clk);
    reti_strobe = 1'b0;
    chk("R9 reti sets", reg_rdata[0], 1'b1);
    ret_strobe = 1'b1;
    @(negedge clk);
    ret_strobe = 1'b0;
    chk("R9 ret keeps on", reg_rdata[0], 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule